// File: doc/BRIEF.md
# USB Power Delivery Timing Tick Chain

This block turns one fast kernel clock into the four timing strobes that a USB Power Delivery physical layer needs. A coded power-of-two prescaler first makes a peripheral tick. That tick feeds two dividers: one makes the half-bit tick and the other makes the inter-frame gap tick. The half-bit tick then feeds a third divider that marks the transition window. Every output is a one-cycle clock enable in the kernel domain. None of them is a derived clock.

Software loads the four ratio fields through a write strobe, but only while the block is disabled. While the block is enabled, the timing stays fixed. A zero in either of the two five-bit fields is not a legal setting. It silences that strobe and sets a sticky error flag, which only reset clears.

Top module: `pd_tick_chain`

## Requirements
- R1: The 3-bit prescaler code c in 0..4 spaces `tickPeriph` pulses 2^c kernel cycles apart (1, 2, 4, 8, 16). The first pulse comes after the 2^c-th rising edge at which `enable` is sampled high.
- R2: Prescaler codes 5, 6 and 7 behave exactly like code 4, so pulses are 16 cycles apart.
- R3: `tickHalfBit` pulses are spaced P*(H+1) kernel cycles apart. Here P is the prescale ratio and H is the 6-bit half-bit field, so H=0 means bypass with one half-bit tick per peripheral tick.
- R4: `tickWindow` pulses are spaced P*(H+1)*(W+1) kernel cycles apart, where W is the 5-bit window field (1..31). This divider counts half-bit ticks.
- R5: `tickGap` pulses are spaced P*(G+1) kernel cycles apart, where G is the 5-bit gap field (1..31). This divider counts peripheral ticks.
- R6: A write (`cfgWrite` high at a clock edge) loads all four fields only when `enable` is low at that edge. A write while enabled changes nothing, either now or after a later re-enable.
- R7: A window or gap field of zero keeps the matching tick output low and leaves the other outputs unaffected. `cfgError` rises once the block is enabled with such a field, and it stays high until reset.
- R8: Reset clears all fields to zero, drives all ticks low and clears `cfgError`. With reset values, the peripheral and half-bit ticks fire every enabled cycle.
- R9: Each tick output is high for one kernel cycle per divided period.
- R10: When `enable` is low at an edge, every divider count clears and every tick is low from that edge on. Re-enabling restarts each divider from a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the chain; low clears all counts |
| cfgWrite | input | 1 | Load strobe for the four ratio fields |
| cfgPresc | input | 3 | Prescaler code |
| cfgHalfBit | input | 6 | Half-bit divider field (ratio = value + 1) |
| cfgWindow | input | 5 | Transition-window divider field (ratio = value + 1) |
| cfgGap | input | 5 | Inter-frame gap divider field (ratio = value + 1) |
| tickPeriph | output | 1 | Prescaled peripheral tick |
| tickHalfBit | output | 1 | Half-bit tick |
| tickWindow | output | 1 | Transition-window tick |
| tickGap | output | 1 | Inter-frame gap tick |
| cfgError | output | 1 | Sticky flag for an enabled zero window or gap field |

## Verification
Tick spacing is measured at the boundary ratio of every field: bypass, 2, 27 and 64 for the half-bit divider; 2, 15 and 32 for the window and gap dividers; and every prescaler code including the three aliased ones. Mixing these settings within single runs separates a wrong cascade source from a wrong ratio. A window error scales with the half-bit setting, while a gap error does not. A write issued while enabled, followed by a re-enable without any write, shows whether the lock drops the write or only defers it. A run straight out of reset checks the zero reset fields and the zero-code suppression together.

// File: rtl/pd_tick_pkg.sv
package pd_tick_pkg;

  parameter int PRESC_CODE_W   = 3;
  parameter int PRESC_MAX_CODE = 4;
  parameter int HB_W           = 6;
  parameter int WIN_W          = 5;
  parameter int GAP_W          = 5;

  // strobes from the control half to the counting half
  typedef struct packed {
    logic run;
    logic winOn;
    logic gapOn;
  } tick_ctrl_t;

endpackage

// File: rtl/pd_tick_div.sv
module pd_tick_div #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic         active,
  input  logic         inTick,
  input  logic [W-1:0] lim,
  output logic         tick
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!run || !active) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (inTick) begin
      if (cnt == lim) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (run && active) |-> (cnt <= lim)); // R9

  AST_DIV_FROM_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> $past(inTick)); // R4

  AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(run && active) |=> !tick); // R10

endmodule

// File: rtl/pd_tick_ctrl.sv
module pd_tick_ctrl
  import pd_tick_pkg::*;
#(
  parameter int PRESC_CODE_W   = 3,
  parameter int PRESC_MAX_CODE = 4,
  parameter int HB_W           = 6,
  parameter int WIN_W          = 5,
  parameter int GAP_W          = 5,
  localparam int PCNT_W        = PRESC_MAX_CODE
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    cfgWrite,
  input  logic [PRESC_CODE_W-1:0] cfgPresc,
  input  logic [HB_W-1:0]         cfgHalfBit,
  input  logic [WIN_W-1:0]        cfgWindow,
  input  logic [GAP_W-1:0]        cfgGap,
  output logic [PCNT_W-1:0]       presLim,
  output logic [HB_W-1:0]         hbLim,
  output logic [WIN_W-1:0]        winLim,
  output logic [GAP_W-1:0]        gapLim,
  output tick_ctrl_t              strobe,
  output logic                    cfgError
);

  logic [PRESC_CODE_W-1:0] prescQ;
  logic [HB_W-1:0]         hbQ;
  logic [WIN_W-1:0]        winQ;
  logic [GAP_W-1:0]        gapQ;
  logic                    winOn;
  logic                    gapOn;

  // configuration only lands while the chain is stopped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescQ <= '0;
      hbQ    <= '0;
      winQ   <= '0;
      gapQ   <= '0;
    end else if (cfgWrite && !enable) begin
      prescQ <= cfgPresc;
      hbQ    <= cfgHalfBit;
      winQ   <= cfgWindow;
      gapQ   <= cfgGap;
    end
  end

  // coded prescaler: codes above the maximum saturate
  always_comb begin
    if (prescQ >= PRESC_CODE_W'(PRESC_MAX_CODE)) begin
      presLim = '1;
    end else begin
      presLim = PCNT_W'((32'd1 << prescQ) - 32'd1);
    end
  end

  assign winOn  = (winQ != '0);
  assign gapOn  = (gapQ != '0);
  assign hbLim  = hbQ;
  assign winLim = winQ;
  assign gapLim = gapQ;

  always_comb begin
    strobe.run   = enable;
    strobe.winOn = winOn;
    strobe.gapOn = gapOn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgError <= 1'b0;
    end else if (enable && (!winOn || !gapOn)) begin
      cfgError <= 1'b1;
    end
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> ($stable(prescQ) && $stable(hbQ) && $stable(winQ) && $stable(gapQ))); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError); // R7

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgError) |-> $past(enable)); // R7

endmodule

// File: rtl/pd_tick_dp.sv
module pd_tick_dp
  import pd_tick_pkg::*;
#(
  parameter int PCNT_W = 4,
  parameter int HB_W   = 6,
  parameter int WIN_W  = 5,
  parameter int GAP_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  tick_ctrl_t        strobe,
  input  logic [PCNT_W-1:0] presLim,
  input  logic [HB_W-1:0]   hbLim,
  input  logic [WIN_W-1:0]  winLim,
  input  logic [GAP_W-1:0]  gapLim,
  output logic              tickPeriph,
  output logic              tickHalfBit,
  output logic              tickWindow,
  output logic              tickGap
);

  pd_tick_div #(.W(PCNT_W)) u_presc (
    .clk(clk), .rstN(rstN), .run(strobe.run), .active(1'b1),
    .inTick(1'b1), .lim(presLim), .tick(tickPeriph)
  );

  pd_tick_div #(.W(HB_W)) u_halfBit (
    .clk(clk), .rstN(rstN), .run(strobe.run), .active(1'b1),
    .inTick(tickPeriph), .lim(hbLim), .tick(tickHalfBit)
  );

  pd_tick_div #(.W(WIN_W)) u_window (
    .clk(clk), .rstN(rstN), .run(strobe.run), .active(strobe.winOn),
    .inTick(tickHalfBit), .lim(winLim), .tick(tickWindow)
  );

  pd_tick_div #(.W(GAP_W)) u_gap (
    .clk(clk), .rstN(rstN), .run(strobe.run), .active(strobe.gapOn),
    .inTick(tickPeriph), .lim(gapLim), .tick(tickGap)
  );

  AST_ALL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> !(tickPeriph || tickHalfBit || tickWindow || tickGap)); // R10

  AST_ZERO_WIN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.winOn |=> !tickWindow); // R7

  AST_ZERO_GAP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.gapOn |=> !tickGap); // R7

  AST_GAP_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    tickGap |-> $past(tickPeriph)); // R5

endmodule

// File: rtl/pd_tick_chain.sv
module pd_tick_chain
  import pd_tick_pkg::*;
#(
  parameter int PRESC_CODE_W   = pd_tick_pkg::PRESC_CODE_W,
  parameter int PRESC_MAX_CODE = pd_tick_pkg::PRESC_MAX_CODE,
  parameter int HB_W           = pd_tick_pkg::HB_W,
  parameter int WIN_W          = pd_tick_pkg::WIN_W,
  parameter int GAP_W          = pd_tick_pkg::GAP_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    cfgWrite,
  input  logic [PRESC_CODE_W-1:0] cfgPresc,
  input  logic [HB_W-1:0]         cfgHalfBit,
  input  logic [WIN_W-1:0]        cfgWindow,
  input  logic [GAP_W-1:0]        cfgGap,
  output logic                    tickPeriph,
  output logic                    tickHalfBit,
  output logic                    tickWindow,
  output logic                    tickGap,
  output logic                    cfgError
);

  localparam int PCNT_W = PRESC_MAX_CODE;

  tick_ctrl_t        strobe;
  logic [PCNT_W-1:0] presLim;
  logic [HB_W-1:0]   hbLim;
  logic [WIN_W-1:0]  winLim;
  logic [GAP_W-1:0]  gapLim;

  pd_tick_ctrl #(
    .PRESC_CODE_W(PRESC_CODE_W), .PRESC_MAX_CODE(PRESC_MAX_CODE),
    .HB_W(HB_W), .WIN_W(WIN_W), .GAP_W(GAP_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWrite(cfgWrite),
    .cfgPresc(cfgPresc), .cfgHalfBit(cfgHalfBit), .cfgWindow(cfgWindow),
    .cfgGap(cfgGap), .presLim(presLim), .hbLim(hbLim), .winLim(winLim),
    .gapLim(gapLim), .strobe(strobe), .cfgError(cfgError)
  );

  pd_tick_dp #(
    .PCNT_W(PCNT_W), .HB_W(HB_W), .WIN_W(WIN_W), .GAP_W(GAP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .presLim(presLim),
    .hbLim(hbLim), .winLim(winLim), .gapLim(gapLim),
    .tickPeriph(tickPeriph), .tickHalfBit(tickHalfBit),
    .tickWindow(tickWindow), .tickGap(tickGap)
  );

endmodule

// File: tb/pd_tick_chain_bench.sv
module pd_tick_chain_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       cfgWrite = 1'b0;
  logic [2:0] cfgPresc = '0;
  logic [5:0] cfgHalfBit = '0;
  logic [4:0] cfgWindow = '0;
  logic [4:0] cfgGap = '0;
  logic       tickPeriph, tickHalfBit, tickWindow, tickGap, cfgError;

  always #4 clk = ~clk;  // 125 MHz

  pd_tick_chain u_pd_tick_chain (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWrite(cfgWrite),
    .cfgPresc(cfgPresc), .cfgHalfBit(cfgHalfBit), .cfgWindow(cfgWindow),
    .cfgGap(cfgGap), .tickPeriph(tickPeriph), .tickHalfBit(tickHalfBit),
    .tickWindow(tickWindow), .tickGap(tickGap), .cfgError(cfgError)
  );

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;
  int tickCount [4];

  // scoreboard: expected spacings per channel (0 periph, 1 half-bit, 2 window, 3 gap)
  int    e0[$], e1[$], e2[$], e3[$];
  string r0[$], r1[$], r2[$], r3[$];

  function automatic void chk(string req, string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endfunction

  function automatic void pushExp(int ch, int v, string r);
    case (ch)
      0: begin e0.push_back(v); r0.push_back(r); end
      1: begin e1.push_back(v); r1.push_back(r); end
      2: begin e2.push_back(v); r2.push_back(r); end
      default: begin e3.push_back(v); r3.push_back(r); end
    endcase
  endfunction

  function automatic void popCmp(int ch, int act);
    int v;
    string r;
    case (ch)
      0: begin if (e0.size() == 0) return; v = e0.pop_front(); r = r0.pop_front(); end
      1: begin if (e1.size() == 0) return; v = e1.pop_front(); r = r1.pop_front(); end
      2: begin if (e2.size() == 0) return; v = e2.pop_front(); r = r2.pop_front(); end
      default: begin if (e3.size() == 0) return; v = e3.pop_front(); r = r3.pop_front(); end
    endcase
    chk(r, $sformatf("spacing ch%0d", ch), act, v);
  endfunction

  function automatic void drain();
    while (e0.size() > 0) begin chk(r0.pop_front(), "missing periph tick", 0, e0.pop_front()); end
    while (e1.size() > 0) begin chk(r1.pop_front(), "missing half-bit tick", 0, e1.pop_front()); end
    while (e2.size() > 0) begin chk(r2.pop_front(), "missing window tick", 0, e2.pop_front()); end
    while (e3.size() > 0) begin chk(r3.pop_front(), "missing gap tick", 0, e3.pop_front()); end
  endfunction

  // monitor: counts enabled edges, measures spacing between pulses
  initial begin
    int  enEdges = 0;
    bit  enPrev = 1'b0;
    int  lastT [4];
    logic [3:0] tk;
    lastT = '{0, -1, -1, -1};
    forever begin
      @(negedge clk);
      if (!rstN) begin
        enPrev = 1'b0;
        enEdges = 0;
        lastT = '{0, -1, -1, -1};
      end else begin
        if (enPrev) enEdges++;
        else begin
          enEdges = 0;
          lastT = '{0, -1, -1, -1};
        end
        tk = {tickGap, tickWindow, tickHalfBit, tickPeriph};
        for (int ch = 0; ch < 4; ch++) begin
          if (tk[ch]) begin
            tickCount[ch]++;
            if (lastT[ch] >= 0) popCmp(ch, enEdges - lastT[ch]);
            lastT[ch] = enEdges;
          end
        end
        enPrev = enable;
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic writeCfg(int p, int h, int w, int g);
    cyc(1);
    cfgWrite = 1'b1;
    cfgPresc = 3'(p);
    cfgHalfBit = 6'(h);
    cfgWindow = 5'(w);
    cfgGap = 5'(g);
    cyc(1);
    cfgWrite = 1'b0;
  endtask

  function automatic int pRatio(int p);
    return (p >= 4) ? 16 : (1 << p);
  endfunction

  // expects one spacing per channel for the given settings; returns the longest
  function automatic int expectSet(int p, int h, int w, int g);
    int n = pRatio(p);
    int hb = n * (h + 1);
    int mx = hb;
    pushExp(0, n, (p > 4) ? "R2" : "R1");
    pushExp(1, hb, "R3");
    if (w != 0) begin
      pushExp(2, hb * (w + 1), "R4");
      if (hb * (w + 1) > mx) mx = hb * (w + 1);
    end
    if (g != 0) begin
      pushExp(3, n * (g + 1), "R5");
      if (n * (g + 1) > mx) mx = n * (g + 1);
    end
    return mx;
  endfunction

  task automatic stopChain();
    int snap [4];
    enable = 1'b0;
    @(posedge clk);
    #1;
    for (int i = 0; i < 4; i++) snap[i] = tickCount[i];
    cyc(12);
    for (int i = 0; i < 4; i++) chk("R10", $sformatf("ticks while disabled ch%0d", i), tickCount[i] - snap[i], 0);
  endtask

  task automatic runCase(int p, int h, int w, int g);
    int mx;
    writeCfg(p, h, w, g);
    mx = expectSet(p, h, w, g);
    for (int i = 0; i < 4; i++) tickCount[i] = 0;
    enable = 1'b1;
    cyc(2 * mx + 20);
    drain();
    if (w == 0) chk("R7", "window ticks with zero field", tickCount[2], 0);
    if (g == 0) chk("R7", "gap ticks with zero field", tickCount[3], 0);
    stopChain();
  endtask

  initial begin
    int mx;
    cyc(4);
    chk("R8", "ticks in reset", int'({tickPeriph, tickHalfBit, tickWindow, tickGap}), 0);
    chk("R8", "cfgError in reset", int'(cfgError), 0);
    rstN = 1'b1;
    cyc(2);
    chk("R8", "cfgError after reset", int'(cfgError), 0);

    // reset field values: bypass prescale and half-bit, zero window and gap
    for (int i = 0; i < 4; i++) tickCount[i] = 0;
    pushExp(0, 1, "R8");
    pushExp(1, 1, "R8");
    enable = 1'b1;
    cyc(40);
    drain();
    chk("R7", "window silent at zero", tickCount[2], 0);
    chk("R7", "gap silent at zero", tickCount[3], 0);
    chk("R7", "cfgError set", int'(cfgError), 1);
    stopChain();

    // boundary ratios and every prescaler code
    runCase(0, 0, 1, 1);
    chk("R7", "cfgError sticky", int'(cfgError), 1);
    runCase(1, 1, 14, 14);
    runCase(2, 26, 31, 31);
    runCase(3, 63, 1, 1);
    runCase(4, 0, 1, 31);
    runCase(5, 1, 1, 14);
    runCase(6, 0, 2, 2);
    runCase(7, 26, 1, 1);
    runCase(0, 1, 0, 3);

    // write lock: a write while enabled is dropped, not deferred
    writeCfg(1, 2, 3, 4);
    mx = expectSet(1, 2, 3, 4);
    enable = 1'b1;
    cyc(5);
    cfgWrite = 1'b1; cfgPresc = 3'd3; cfgHalfBit = 6'd10; cfgWindow = 5'd10; cfgGap = 5'd10;
    cyc(1);
    cfgWrite = 1'b0;
    cyc(2 * mx + 20);
    drain();
    stopChain();
    mx = expectSet(1, 2, 3, 4);
    enable = 1'b1;
    cyc(2 * mx + 20);
    drain();
    stopChain();
    runCase(3, 10, 10, 10);

    // reset clears the sticky flag
    rstN = 1'b0;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
    chk("R8", "cfgError cleared by reset", int'(cfgError), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule